// File: doc/BRIEF.md
# Programmable Interval Timer with Tagged Interrupt

This block is a per-CPU interval timer that sits on a simple register bus. Software loads an interval measured in bus clock cycles, then writes a control word that starts the timer and also names the interrupt it should raise: an 8-bit hard IRQ number and a 4-bit priority. While running, the timer emits a one-cycle interrupt strobe every interval. Each strobe carries the IRQ number and priority that were current when it fired. The timer keeps firing until software writes a control word with the run bit clear. To use it as a one-shot, the interrupt handler disables it.

A read-only register reports the bus clock period in nanoseconds, so software can convert time into interval counts. A second register exposes the live down-count. A build-time mapping parameter selects how the IRQ code is formed. In direct mode the number and priority pass through unchanged. In folded mode only codes 64 to 127 can be produced: the number's top two bits are dropped and the priority, shifted left by two, is ORed into the low six bits.

Top module: `pit_timer`

## Requirements
- R1: The control register is at byte offset 0x00. Bit 26 is run, bits 23:20 are the priority and bits 19:12 are the IRQ number. A read returns exactly those fields in those positions, with every other bit reading 0.
- R2: The interval register is at offset 0x10. It holds all 32 written bits and reads them back.
- R3: The register at offset 0x18 reads as the parameter BUS_PERIOD_NS, and writes to it are ignored. A read takes effect on the edge where rd_en is high, and rdata holds the value from the following cycle on. Unmapped offsets read 0.
- R4: The register at offset 0x14 reads the live count, and writes to it are ignored. A control write with run=1 loads the count with the interval, and the count then falls by one each cycle. While the timer is stopped, the count holds.
- R5: Suppose a control write with run=1 is taken on edge E0 and the effective interval is N. Then irq_pulse is high for exactly the cycles following edges E0+N, E0+2N, and so on. Each pulse lasts one cycle when N>1.
- R6: An interval of 0 behaves as an interval of 1: the count loads 1 and a pulse follows every edge.
- R7: A control write with run=0 stops the timer. No pulse follows that write's edge or any later edge, even when the count would have expired on that same edge.
- R8: A control write with run=1 while the timer is running restarts the count from the current interval. Writing the interval register alone does not restart the count.
- R9: With MAP_MODE=0, irq_num equals the IRQ field and irq_prio equals the priority field, both taken from the control register in effect when the pulse fired.
- R10: With MAP_MODE=1, irq_num is 64 + ((IRQ field & 63) | (priority << 2)), and irq_prio equals the priority field.
- R11: After reset the timer is stopped, the control register reads 0, and irq_pulse, irq_num, irq_prio and the count are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| addr | input | 8 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |
| irq_pulse | output | 1 | One-cycle interrupt strobe |
| irq_num | output | 8 | IRQ code attached to the latest strobe |
| irq_prio | output | 4 | Priority attached to the latest strobe |

## Verification
The pulse timing is swept over every interval from 0 to 7, across three full periods each. This separates the zero-means-one case, the back-to-back case at N=1, and off-by-one reload errors at larger N. Tagging is swept over all 16 priorities against 16 IRQ numbers spread across the whole 8-bit range, on one instance of each mapping mode. Folded codes are computed arithmetically, which exposes a wrong shift, wrong masking of the top bits or a wrong OR. Dedicated sequences place a disable write on the exact expiry edge and a re-enable in the middle of a count, which distinguishes a true restart from a reload that only happens on expiry.

// File: rtl/pit_pkg.sv
package pit_pkg;

    localparam int ADDR_W   = 8;
    localparam int DATA_W   = 32;
    localparam int RUN_BIT  = 26;
    localparam int PRIO_LSB = 20;
    localparam int IRQ_LSB  = 12;
    localparam int PRIO_W   = 4;
    localparam int IRQ_W    = 8;

    localparam logic [ADDR_W-1:0] OFF_CTRL   = 8'h00;
    localparam logic [ADDR_W-1:0] OFF_IVAL   = 8'h10;
    localparam logic [ADDR_W-1:0] OFF_COUNT  = 8'h14;
    localparam logic [ADDR_W-1:0] OFF_PERIOD = 8'h18;

    typedef enum logic {
        MAP_DIRECT = 1'b0,
        MAP_FOLD   = 1'b1
    } map_mode_e;

    typedef struct packed {
        logic              run;
        logic [PRIO_W-1:0] prio;
        logic [IRQ_W-1:0]  irq;
    } ctrl_t;

    typedef struct packed {
        logic [IRQ_W-1:0]  num;
        logic [PRIO_W-1:0] prio;
    } tag_t;

    function automatic ctrl_t ctrl_from_word(input logic [DATA_W-1:0] w);
        ctrl_t c;
        c.run  = w[RUN_BIT];
        c.prio = w[PRIO_LSB +: PRIO_W];
        c.irq  = w[IRQ_LSB +: IRQ_W];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] word_from_ctrl(input ctrl_t c);
        logic [DATA_W-1:0] w;
        w = '0;
        w[RUN_BIT]              = c.run;
        w[PRIO_LSB +: PRIO_W]   = c.prio;
        w[IRQ_LSB +: IRQ_W]     = c.irq;
        return w;
    endfunction

    function automatic logic [IRQ_W-1:0] fold_code(input logic [5:0] irq_lo,
                                                   input logic [PRIO_W-1:0] prio);
        return {2'b01, irq_lo | {prio, 2'b00}};
    endfunction

endpackage

// File: rtl/pit_regs.sv
module pit_regs
    import pit_pkg::*;
#(
    parameter int BUS_PERIOD_NS = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] count_q,
    output ctrl_t             ctrl,
    output logic [DATA_W-1:0] interval,
    output logic              ctrl_wr,
    output logic [DATA_W-1:0] rdata
);

    localparam logic [DATA_W-1:0] PERIOD_WORD = DATA_W'(BUS_PERIOD_NS);

    logic [DATA_W-1:0] rd_mux;

    assign ctrl_wr = wr_en && (addr == OFF_CTRL);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl     <= '0;
            interval <= '0;
        end else begin
            if (ctrl_wr)
                ctrl <= ctrl_from_word(wdata);
            if (wr_en && addr == OFF_IVAL)
                interval <= wdata;
        end
    end

    always_comb begin
        case (addr)
            OFF_CTRL:   rd_mux = word_from_ctrl(ctrl);
            OFF_IVAL:   rd_mux = interval;
            OFF_COUNT:  rd_mux = count_q;
            OFF_PERIOD: rd_mux = PERIOD_WORD;
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata <= '0;
        else if (rd_en)
            rdata <= rd_mux;
    end

endmodule

// File: rtl/pit_counter.sv
module pit_counter
    import pit_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              halt,
    input  logic              run,
    input  logic [DATA_W-1:0] load_val,
    output logic [DATA_W-1:0] count_q,
    output logic              expire
);

    assign expire = run && !halt && (count_q <= DATA_W'(1));

    always_ff @(posedge clk) begin
        if (rst)
            count_q <= '0;
        else if (start || expire)
            count_q <= load_val;
        else if (run && !halt)
            count_q <= count_q - DATA_W'(1);
    end

endmodule

// File: rtl/pit_irq_map.sv
module pit_irq_map
    import pit_pkg::*;
#(
    parameter map_mode_e MAP_MODE = MAP_DIRECT
) (
    input  logic [IRQ_W-1:0]  irq,
    input  logic [PRIO_W-1:0] prio,
    output tag_t              tag
);

    generate
        if (MAP_MODE == MAP_FOLD) begin : g_fold
            logic unused_hi;
            assign unused_hi = ^irq[7:6];
            assign tag.num   = fold_code(irq[5:0], prio);
            assign tag.prio  = prio;
        end else begin : g_direct
            assign tag.num  = irq;
            assign tag.prio = prio;
        end
    endgenerate

endmodule

// File: rtl/pit_timer.sv
module pit_timer
    import pit_pkg::*;
#(
    parameter int        BUS_PERIOD_NS = 20,
    parameter map_mode_e MAP_MODE      = MAP_DIRECT
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        rd_en,
    input  logic        wr_en,
    input  logic [7:0]  addr,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    output logic        irq_pulse,
    output logic [7:0]  irq_num,
    output logic [3:0]  irq_prio
);

    ctrl_t             ctrl;
    tag_t              tag_now;
    logic [DATA_W-1:0] interval;
    logic [DATA_W-1:0] load_val;
    logic [DATA_W-1:0] count_q;
    logic              ctrl_wr;
    logic              start;
    logic              expire;

    pit_regs #(.BUS_PERIOD_NS(BUS_PERIOD_NS)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .rd_en    (rd_en),
        .wr_en    (wr_en),
        .addr     (addr),
        .wdata    (wdata),
        .count_q  (count_q),
        .ctrl     (ctrl),
        .interval (interval),
        .ctrl_wr  (ctrl_wr),
        .rdata    (rdata)
    );

    assign load_val = (interval == '0) ? DATA_W'(1) : interval;
    assign start    = ctrl_wr && wdata[RUN_BIT];

    pit_counter u_cnt (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .halt     (ctrl_wr),
        .run      (ctrl.run),
        .load_val (load_val),
        .count_q  (count_q),
        .expire   (expire)
    );

    pit_irq_map #(.MAP_MODE(MAP_MODE)) u_map (
        .irq  (ctrl.irq),
        .prio (ctrl.prio),
        .tag  (tag_now)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_pulse <= 1'b0;
            irq_num   <= '0;
            irq_prio  <= '0;
        end else begin
            irq_pulse <= expire;
            if (expire) begin
                irq_num  <= tag_now.num;
                irq_prio <= tag_now.prio;
            end
        end
    end

endmodule

// File: rtl/pit_timer_chk.sv
module pit_timer_chk
    import pit_pkg::*;
#(
    parameter map_mode_e MAP_MODE = MAP_DIRECT
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [7:0]        addr,
    input logic [31:0]       wdata,
    input logic              irq_pulse,
    input logic [7:0]        irq_num,
    input logic              run,
    input logic [DATA_W-1:0] load_val,
    input logic [DATA_W-1:0] count_q
);

    logic stop_wr;
    logic go_wr;
    assign stop_wr = wr_en && (addr == OFF_CTRL) && !wdata[RUN_BIT];
    assign go_wr   = wr_en && (addr == OFF_CTRL) && wdata[RUN_BIT];

    AST_PULSE_NEEDS_RUN: assert property (@(posedge clk) disable iff (rst)
        irq_pulse |-> $past(run)); // R7

    AST_STOP_SILENCES: assert property (@(posedge clk) disable iff (rst)
        stop_wr |=> !irq_pulse); // R7

    AST_START_LOADS: assert property (@(posedge clk) disable iff (rst)
        go_wr |=> (count_q == $past(load_val))); // R4

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (irq_pulse && $past(load_val) > 1) |=> !irq_pulse); // R5

    AST_FOLD_RANGE: assert property (@(posedge clk) disable iff (rst)
        (MAP_MODE == MAP_FOLD && irq_pulse) |-> (irq_num[7:6] == 2'b01)); // R10

endmodule

bind pit_timer pit_timer_chk #(.MAP_MODE(MAP_MODE)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .addr      (addr),
    .wdata     (wdata),
    .irq_pulse (irq_pulse),
    .irq_num   (irq_num),
    .run       (ctrl.run),
    .load_val  (load_val),
    .count_q   (count_q)
);

// File: tb/pit_timer_tb.sv
module pit_timer_tb;
    import pit_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int PERIOD_NS  = 20;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata, rdata_f;
    logic        irq_pulse, irq_pulse_f;
    logic [7:0]  irq_num, irq_num_f;
    logic [3:0]  irq_prio, irq_prio_f;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pit_timer #(.BUS_PERIOD_NS(PERIOD_NS), .MAP_MODE(MAP_DIRECT)) u_dut (
        .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq_pulse(irq_pulse),
        .irq_num(irq_num), .irq_prio(irq_prio)
    );

    pit_timer #(.BUS_PERIOD_NS(PERIOD_NS), .MAP_MODE(MAP_FOLD)) u_dut_fold (
        .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata_f), .irq_pulse(irq_pulse_f),
        .irq_num(irq_num_f), .irq_prio(irq_prio_f)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    function automatic logic [31:0] ctl(input bit run, input int prio, input int irq);
        return (32'(run) << 26) | (32'(prio & 15) << 20) | (32'(irq & 255) << 12);
    endfunction

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_up();
    end

    initial begin
        logic [31:0] v, v2;
        int eff;
        @(negedge clk);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R11 reset state
        check(irq_pulse == 0, "R11 pulse", irq_pulse, 0);
        check(irq_num == 0 && irq_prio == 0, "R11 tag", {irq_num, irq_prio}, 0);
        bus_rd(8'h00, v); check(v == 0, "R11 ctrl", v, 0);
        bus_rd(8'h14, v); check(v == 0, "R11 count", v, 0);

        // R1 field layout
        bus_wr(8'h00, 32'hFFFF_FFFF);
        bus_rd(8'h00, v); check(v == 32'h04FF_F000, "R1 all ones", v, 32'h04FF_F000);
        bus_wr(8'h00, ctl(0, 3, 8'hA5));
        bus_rd(8'h00, v); check(v == 32'h003A_5000, "R1 fields", v, 32'h003A_5000);
        bus_wr(8'h00, 0);

        // R2 interval register
        bus_wr(8'h10, 32'hDEAD_BEEF);
        bus_rd(8'h10, v); check(v == 32'hDEAD_BEEF, "R2 readback", v, 32'hDEAD_BEEF);

        // R3 period register and unmapped offset
        bus_rd(8'h18, v); check(v == PERIOD_NS, "R3 period", v, PERIOD_NS);
        bus_wr(8'h18, 32'd123);
        bus_rd(8'h18, v); check(v == PERIOD_NS, "R3 write ignored", v, PERIOD_NS);
        bus_rd(8'h3C, v); check(v == 0, "R3 unmapped", v, 0);

        // R4 live count
        bus_wr(8'h10, 32'd1000);
        bus_wr(8'h00, ctl(1, 0, 0));
        bus_rd(8'h14, v);  check(v == 1000, "R4 load", v, 1000);
        bus_rd(8'h14, v2); check(v2 == 999, "R4 decrement", v2, 999);
        bus_wr(8'h00, 0);
        bus_rd(8'h14, v);
        bus_wr(8'h14, 32'd5);
        bus_rd(8'h14, v2); check(v2 == v, "R4 write ignored and hold", v2, v);

        // R6 zero interval loads 1
        bus_wr(8'h10, 0);
        bus_wr(8'h00, ctl(1, 0, 0));
        bus_rd(8'h14, v); check(v == 1, "R6 zero loads one", v, 1);
        bus_wr(8'h00, 0);

        // R5 / R6 sweep of intervals 0..7
        for (int n = 0; n < 8; n++) begin
            eff = (n == 0) ? 1 : n;
            bus_wr(8'h10, n);
            bus_wr(8'h00, ctl(1, 1, 7));
            check(irq_pulse == 0, "R5 no pulse on start edge", irq_pulse, 0);
            for (int i = 1; i <= 3 * eff; i++) begin
                @(negedge clk);
                check(irq_pulse == ((i % eff) == 0), (n == 0) ? "R6 period" : "R5 period",
                      irq_pulse, (i % eff) == 0);
            end
            bus_wr(8'h00, 0);
        end

        // R7 disable on the expiry edge
        bus_wr(8'h10, 3);
        bus_wr(8'h00, ctl(1, 0, 0));
        @(negedge clk); @(negedge clk);
        check(irq_pulse == 0, "R7 before expiry", irq_pulse, 0);
        bus_wr(8'h00, 0);
        for (int i = 0; i < 20; i++) begin
            check(irq_pulse == 0 && irq_pulse_f == 0, "R7 stopped", irq_pulse, 0);
            @(negedge clk);
        end

        // R8 restart mid count
        bus_wr(8'h10, 6);
        bus_wr(8'h00, ctl(1, 0, 0));
        @(negedge clk); @(negedge clk); @(negedge clk);
        bus_wr(8'h10, 4);
        bus_wr(8'h00, ctl(1, 0, 0));
        for (int i = 1; i <= 8; i++) begin
            @(negedge clk);
            check(irq_pulse == ((i % 4) == 0), "R8 restart", irq_pulse, (i % 4) == 0);
        end
        bus_wr(8'h00, 0);

        // R9 / R10 tag sweep
        bus_wr(8'h10, 0);
        for (int p = 0; p < 16; p++) begin
            for (int j = 0; j < 16; j++) begin
                int q;
                int fexp;
                q = j * 17;
                fexp = 64 + ((q & 63) | (p << 2));
                bus_wr(8'h00, ctl(1, p, q));
                @(negedge clk);
                check(irq_pulse == 1, "R9 pulse", irq_pulse, 1);
                check(irq_num == q && irq_prio == p, "R9 direct tag",
                      {irq_num, irq_prio}, {q[7:0], p[3:0]});
                check(irq_num_f == fexp && irq_prio_f == p, "R10 folded tag",
                      {irq_num_f, irq_prio_f}, {fexp[7:0], p[3:0]});
            end
        end
        bus_wr(8'h00, 0);

        finish_up();
    end

endmodule